// File: doc/BRIEF.md
# Byte-Wide Table-Driven CRC-32 Engine

This block folds one message byte per clock into a 32-bit cyclic redundancy check. It does not push trailing zero bytes through the register. Before each step it XORs the incoming byte with the CRC byte that is about to leave the register, and that value selects one of 256 precomputed table words. The register then shifts by eight with zeros entering, and the selected word is XORed in. The remainder is therefore complete as soon as the last message byte has been absorbed.

A build-time parameter picks one of two variants. The straight variant shifts left, takes the index from the top byte and consumes each byte most significant bit first. The mirrored variant shifts right, takes the index from the low byte, uses a table whose words are the bit-reversed straight words, and consumes each byte least significant bit first. This lets bytes leave a serial link in their natural order without reordering their bits. The mirrored variant bit-reverses the register when it presents the result. The table comes from a constant function evaluated at elaboration. The register starts at zero and no output XOR is applied.

In use, a source presents bytes with a valid strobe and marks the final byte of a message. One cycle later the block presents the remainder together with a one-cycle completion pulse. It then starts the next message from zero on its own. A synchronous clear abandons a message part-way through.

Top module: `crc32_bytetab_top`

## Requirements
- R1: Straight variant (MIRROR=0): each accepted byte forms index = byte XOR crc[31:24], then crc becomes (crc << 8) XOR T[index], where T[i] is the remainder of i·x^32 divided by the generator. The result equals a bit-serial CRC that takes bit 7 of each byte first, starting from zero.
- R2: Straight variant: the result equals the plain long-division remainder of the message followed by 32 zero bits, shifted in most significant bit first.
- R3: Mirrored variant (MIRROR=1): index = byte XOR crc[7:0], and crc becomes (crc >> 8) XOR M[index], where M[i] is the 32-bit reverse of T[reverse8(i)]. The presented result is the 32-bit reverse of the register. This equals a bit-serial CRC that takes bit 0 of each byte first, feeds back through the reversed generator and is reversed at the end.
- R4: After reset, the CRC register is zero, crc_o is zero and done_o is low.
- R5: clr_i zeroes the CRC register and takes priority over a byte offered in the same cycle. That byte is discarded, and if it is marked last, no done_o pulse follows.
- R6: A cycle with byte_vld_i low leaves the CRC register unchanged, so gaps between bytes do not alter the result.
- R7: When a byte marked last is accepted, crc_o shows the remainder and done_o is high in the following cycle. done_o is high for exactly that cycle unless another last byte is accepted, and crc_o holds until the next completed message.
- R8: After a last byte is accepted, the register restarts from zero, so the next message needs no clear.
- R9: A single-byte message gives the generator value itself: byte 0x01 in the straight variant and byte 0x80 in the mirrored variant. Byte 0x00 gives zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr_i | input | 1 | Synchronous clear of the CRC register |
| byte_vld_i | input | 1 | Byte on byte_i is offered this cycle |
| byte_i | input | 8 | Message byte |
| byte_last_i | input | 1 | Offered byte ends the message |
| crc_o | output | 32 | Remainder of the last completed message |
| done_o | output | 1 | One-cycle pulse: crc_o has just been updated |

## Verification
Every result is due one clock after the edge that accepts the last byte. The bench drives inputs on the falling edge, deasserts the strobe at the next falling edge and samples crc_o and done_o there, which is half a cycle after the register edge. One falling edge later it confirms that done_o has dropped and crc_o has held. A clear, or a cycle with the strobe low, has no visible output of its own. Its effect is therefore read one message later, by comparing the completed remainder against bit-serial models computed in the bench. Both variants run side by side on the same stimulus over several message lengths.

// File: rtl/crc32_bt_pkg.sv
package crc32_bt_pkg;
  localparam int CRC_W  = 32;
  localparam int BYTE_W = 8;
  localparam int TAB_N  = 1 << BYTE_W;

  function automatic logic [CRC_W-1:0] rev_crc(input logic [CRC_W-1:0] v);
    logic [CRC_W-1:0] r;
    for (int k = 0; k < CRC_W; k++) r[k] = v[CRC_W-1-k];
    return r;
  endfunction

  function automatic logic [BYTE_W-1:0] rev_byte(input logic [BYTE_W-1:0] v);
    logic [BYTE_W-1:0] r;
    for (int k = 0; k < BYTE_W; k++) r[k] = v[BYTE_W-1-k];
    return r;
  endfunction

  // Remainder of idx * x^CRC_W, MSB-first division.
  function automatic logic [CRC_W-1:0] straight_word(input logic [CRC_W-1:0] gen,
                                                     input logic [BYTE_W-1:0] idx);
    logic [CRC_W-1:0] r;
    r = {idx, {(CRC_W-BYTE_W){1'b0}}};
    for (int k = 0; k < BYTE_W; k++)
      r = r[CRC_W-1] ? ((r << 1) ^ gen) : (r << 1);
    return r;
  endfunction

  function automatic logic [CRC_W-1:0] table_word(input logic [CRC_W-1:0] gen,
                                                  input bit mirror,
                                                  input logic [BYTE_W-1:0] idx);
    if (mirror) return rev_crc(straight_word(gen, rev_byte(idx)));
    return straight_word(gen, idx);
  endfunction
endpackage

// File: rtl/crc32_bt_lut.sv
module crc32_bt_lut
  import crc32_bt_pkg::*;
#(
  parameter logic [CRC_W-1:0] GEN    = 32'h04C1_1DB7,
  parameter bit               MIRROR = 1'b0
) (
  input  logic [BYTE_W-1:0] idx_i,
  output logic [CRC_W-1:0]  word_o
);
  logic [CRC_W-1:0] rom [TAB_N];

  for (genvar i = 0; i < TAB_N; i++) begin : g_rom
    localparam logic [CRC_W-1:0] WORD = table_word(GEN, MIRROR, BYTE_W'(i));
    assign rom[i] = WORD;
  end

  assign word_o = rom[idx_i];
endmodule

// File: rtl/crc32_bt_step.sv
module crc32_bt_step
  import crc32_bt_pkg::*;
#(
  parameter logic [CRC_W-1:0] GEN    = 32'h04C1_1DB7,
  parameter bit               MIRROR = 1'b0
) (
  input  logic [CRC_W-1:0]  crc_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [CRC_W-1:0]  crc_nxt_o
);
  logic [BYTE_W-1:0] idx;
  logic [CRC_W-1:0]  word;
  logic [CRC_W-1:0]  shifted;

  if (MIRROR) begin : g_right
    always_comb begin
      idx     = byte_i ^ crc_i[BYTE_W-1:0];
      shifted = {{BYTE_W{1'b0}}, crc_i[CRC_W-1:BYTE_W]};
    end
  end else begin : g_left
    always_comb begin
      idx     = byte_i ^ crc_i[CRC_W-1:CRC_W-BYTE_W];
      shifted = {crc_i[CRC_W-BYTE_W-1:0], {BYTE_W{1'b0}}};
    end
  end

  crc32_bt_lut #(.GEN(GEN), .MIRROR(MIRROR)) lut_i (
    .idx_i  (idx),
    .word_o (word)
  );

  assign crc_nxt_o = shifted ^ word;
endmodule

// File: rtl/crc32_bt_result.sv
module crc32_bt_result
  import crc32_bt_pkg::*;
#(
  parameter bit MIRROR = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CRC_W-1:0] crc_i,
  output logic [CRC_W-1:0] crc_o,
  output logic             done_o
);
  logic [CRC_W-1:0] shown;
  logic [CRC_W-1:0] res_d, res_q;
  logic             done_d, done_q;

  if (MIRROR) begin : g_rev
    assign shown = rev_crc(crc_i);
  end else begin : g_pass
    assign shown = crc_i;
  end

  always_comb begin
    res_d  = res_q;
    done_d = load_i;
    if (load_i) res_d = shown;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      res_q  <= res_d;
      done_q <= done_d;
    end
  end

  assign crc_o  = res_q;
  assign done_o = done_q;

  a_r7_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(res_q));
endmodule

// File: rtl/crc32_bytetab_top.sv
module crc32_bytetab_top
  import crc32_bt_pkg::*;
#(
  parameter logic [31:0] GEN    = 32'h04C1_1DB7,
  parameter bit          MIRROR = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr_i,
  input  logic        byte_vld_i,
  input  logic [7:0]  byte_i,
  input  logic        byte_last_i,
  output logic [31:0] crc_o,
  output logic        done_o
);
  logic             rst_meta, rst_sync;
  logic [CRC_W-1:0] crc_d, crc_q, crc_nxt;
  logic             take, finish;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  assign take   = byte_vld_i & ~clr_i;
  assign finish = take & byte_last_i;

  crc32_bt_step #(.GEN(GEN), .MIRROR(MIRROR)) step_i (
    .crc_i     (crc_q),
    .byte_i    (byte_i),
    .crc_nxt_o (crc_nxt)
  );

  always_comb begin
    crc_d = crc_q;
    if (clr_i)       crc_d = '0;
    else if (finish) crc_d = '0;
    else if (take)   crc_d = crc_nxt;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) crc_q <= '0;
    else           crc_q <= crc_d;
  end

  crc32_bt_result #(.MIRROR(MIRROR)) res_i (
    .clk    (clk),
    .rst_n  (rst_sync),
    .load_i (finish),
    .crc_i  (crc_nxt),
    .crc_o  (crc_o),
    .done_o (done_o)
  );

  a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_sync)
    clr_i |=> (crc_q == '0));
  a_r5_clear_no_done: assert property (@(posedge clk) disable iff (!rst_sync)
    clr_i |=> !done_o);
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_sync)
    (!clr_i && !byte_vld_i) |=> $stable(crc_q));
  a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_sync)
    (byte_vld_i && byte_last_i && !clr_i) |=> done_o);
  a_r7_done_only_after_last: assert property (@(posedge clk) disable iff (!rst_sync)
    !(byte_vld_i && byte_last_i && !clr_i) |=> !done_o);
  a_r8_restart_zero: assert property (@(posedge clk) disable iff (!rst_sync)
    (byte_vld_i && byte_last_i) |=> (crc_q == '0));
  a_r9_zero_byte_fixed: assert property (@(posedge clk) disable iff (!rst_sync)
    (crc_q == '0 && byte_vld_i && byte_i == 8'h00) |=> (crc_q == '0));
endmodule

// File: tb/crc32_bytetab_top_tb_top.sv
module crc32_bytetab_top_tb_top;
  localparam logic [31:0] GEN = 32'h04C1_1DB7;

  logic        clk = 1'b0;
  logic        rst_n, clr, vld, last;
  logic [7:0]  byt;
  logic [31:0] crc_s, crc_m;
  logic        done_s, done_m;
  int          n_run = 0, n_fail = 0;
  logic [7:0]  msg [64];

  always #2 clk = ~clk;

  crc32_bytetab_top #(.GEN(GEN), .MIRROR(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .byte_vld_i(vld), .byte_i(byt),
    .byte_last_i(last), .crc_o(crc_s), .done_o(done_s));

  crc32_bytetab_top #(.GEN(GEN), .MIRROR(1'b1)) dut_m_i (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .byte_vld_i(vld), .byte_i(byt),
    .byte_last_i(last), .crc_o(crc_m), .done_o(done_m));

  function automatic logic [31:0] rev32(input logic [31:0] v);
    logic [31:0] r;
    for (int k = 0; k < 32; k++) r[k] = v[31-k];
    return r;
  endfunction

  function automatic logic [31:0] ref_straight(input int n);
    logic [31:0] r = '0;
    logic fb;
    for (int i = 0; i < n; i++)
      for (int b = 7; b >= 0; b--) begin
        fb = r[31] ^ msg[i][b];
        r  = r << 1;
        if (fb) r = r ^ GEN;
      end
    return r;
  endfunction

  function automatic logic [31:0] ref_augmented(input int n);
    logic [31:0] r = '0;
    logic top, bitv;
    for (int k = 0; k < n * 8 + 32; k++) begin
      bitv = (k < n * 8) ? msg[k / 8][7 - (k % 8)] : 1'b0;
      top  = r[31];
      r    = {r[30:0], bitv};
      if (top) r = r ^ GEN;
    end
    return r;
  endfunction

  function automatic logic [31:0] ref_mirror(input int n);
    logic [31:0] r = '0;
    logic [31:0] g = rev32(GEN);
    logic fb;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++) begin
        fb = r[0] ^ msg[i][b];
        r  = r >> 1;
        if (fb) r = r ^ g;
      end
    return rev32(r);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Sends msg[0..n-1]; gap inserts an idle cycle after each non-final byte.
  task automatic send(input int n, input bit gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      vld = 1'b1; byt = msg[i]; last = (i == n - 1);
      if (gap && i != n - 1) begin
        @(negedge clk);
        vld = 1'b0; last = 1'b0;
      end
    end
    @(negedge clk);
    vld = 1'b0; last = 1'b0;
  endtask

  task automatic check_result(input int n, input string tag);
    logic [31:0] es, em;
    es = ref_straight(n);
    em = ref_mirror(n);
    chk(done_s === 1'b1, {tag, " R7 done straight"}, 32'(done_s), 32'd1);
    chk(done_m === 1'b1, {tag, " R7 done mirror"}, 32'(done_m), 32'd1);
    chk(crc_s === es, {tag, " R1 straight crc"}, crc_s, es);
    chk(crc_m === em, {tag, " R3 mirror crc"}, crc_m, em);
  endtask

  task automatic t_reset;
    chk(crc_s === 32'h0 && done_s === 1'b0, "R4 straight reset", crc_s, 32'h0);
    chk(crc_m === 32'h0 && done_m === 1'b0, "R4 mirror reset", crc_m, 32'h0);
  endtask

  task automatic t_single;
    msg[0] = 8'h01; send(1, 1'b0);
    chk(crc_s === GEN, "R9 straight byte 01", crc_s, GEN);
    msg[0] = 8'h80; send(1, 1'b0);
    chk(crc_m === GEN, "R9 mirror byte 80", crc_m, GEN);
    msg[0] = 8'h00; send(1, 1'b0);
    chk(crc_s === 32'h0 && crc_m === 32'h0, "R9 zero byte", crc_s | crc_m, 32'h0);
  endtask

  task automatic t_random;
    int n;
    logic [31:0] ea;
    for (int r = 0; r < 12; r++) begin
      n = (r < 4) ? r + 2 : 1 + int'($urandom_range(63));
      for (int i = 0; i < n; i++) msg[i] = 8'($urandom);
      send(n, 1'b0);
      check_result(n, "random");
      ea = ref_augmented(n);
      chk(crc_s === ea, "R2 augmented match", crc_s, ea);
      @(negedge clk);
      chk(done_s === 1'b0 && done_m === 1'b0, "R7 done one cycle",
          32'({done_s, done_m}), 32'h0);
    end
  endtask

  task automatic t_gaps;
    for (int i = 0; i < 9; i++) msg[i] = 8'(8'hA5 + 8'(i * 37));
    send(9, 1'b1);
    check_result(9, "gaps R6");
  endtask

  task automatic t_clear;
    logic [31:0] held;
    for (int i = 0; i < 5; i++) msg[i] = 8'(i * 11 + 3);
    send(5, 1'b0);
    held = crc_s;
    // partial message, then clear with a last byte that must be dropped
    @(negedge clk); vld = 1'b1; byt = 8'h5A; last = 1'b0;
    @(negedge clk); vld = 1'b1; byt = 8'hC3; last = 1'b1; clr = 1'b1;
    @(negedge clk); vld = 1'b0; last = 1'b0; clr = 1'b0;
    chk(done_s === 1'b0 && done_m === 1'b0, "R5 no done on cleared last",
        32'({done_s, done_m}), 32'h0);
    chk(crc_s === held, "R5 crc_o held across clear", crc_s, held);
    for (int i = 0; i < 7; i++) msg[i] = 8'(8'hF0 ^ 8'(i));
    send(7, 1'b0);
    check_result(7, "after clear R5");
  endtask

  task automatic t_back_to_back;
    for (int i = 0; i < 3; i++) msg[i] = 8'(8'h31 + 8'(i));
    send(3, 1'b0);
    check_result(3, "first R8");
    for (int i = 0; i < 4; i++) msg[i] = 8'(8'h77 - 8'(i));
    send(4, 1'b0);
    check_result(4, "second R8");
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clr = 1'b0; vld = 1'b0; last = 1'b0; byt = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_single();
    t_random();
    t_gaps();
    t_clear();
    t_back_to_back();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule